// File: doc/BRIEF.md
# ADC Offset and Gain Correction Datapath

This block sits between a sigma-delta converter's decimation filter and the output data register. Each raw conversion code arrives as a 24-bit two's-complement value. The block first removes a programmable offset from it. It then multiplies the difference by a fractional full-scale coefficient. Finally it maps the scaled value onto a 24-bit unsigned output code, using either a unipolar or a bipolar mapping.

With the reset coefficient the gain is close to 4/3. That value undoes the 3/4 attenuation the analog path applies ahead of conversion. Because the offset is removed before the multiply, one step of the offset coefficient moves the output by the gain factor, not by one output step.

A host loads either coefficient through a one-cycle write port. For a zero-scale calibration, the sample taken with the zero-scale input applied is flagged with a calibration request. The block then stores into the offset coefficient the value that nulls that input, so the host does no arithmetic of its own.

Top module: `adc_cal_datapath`

## Requirements
- R1: After reset the offset coefficient is 0x800000, the full-scale coefficient is 0x555555, and `out_valid`, `out_ovf` and `cal_done` are low.
- R2: The raw code (24-bit two's complement) first has (offset − 0x800000) subtracted from it, giving difference D. D is then multiplied by full_scale/2^22, and the result is rounded toward negative infinity to give S. One offset step therefore moves S by full_scale/2^22.
- R3: With `mode_bipolar` low, the output code is 2·S.
- R4: With `mode_bipolar` high, the output code is S + 0x800000.
- R5: Results below 0 are clamped to 0x000000, and results above 0xFFFFFF are clamped to 0xFFFFFF. `out_ovf` is high exactly in the cycle a clamped result is presented with `out_valid`.
- R6: A sample accepted on a rising edge (`in_valid` high, `cal_req` low) appears with `out_valid` after the following rising edge. Samples may arrive back to back. No other cycle raises `out_valid`.
- R7: With `wr_en` high, `wr_sel` = 0 writes the offset coefficient and `wr_sel` = 1 writes the full-scale coefficient. The write is used from the next accepted sample onward. A sample accepted on the same edge as the write still uses the old value.
- R8: A sample with `cal_req` high produces no data output. It loads the offset coefficient with raw XOR 0x800000, so the same raw code afterwards gives S = 0. `cal_done` pulses for one cycle after that edge.
- R9: If a calibration capture and an offset write fall on the same edge, the calibration capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw code present this cycle |
| in_code | input | 24 | Raw conversion code, two's complement |
| cal_req | input | 1 | Treat this sample as a zero-scale calibration reading |
| mode_bipolar | input | 1 | 1: bipolar mapping, 0: unipolar mapping |
| wr_en | input | 1 | Coefficient write strobe |
| wr_sel | input | 1 | 0: offset coefficient, 1: full-scale coefficient |
| wr_data | input | 24 | Coefficient write value |
| out_valid | output | 1 | Corrected code valid |
| out_code | output | 24 | Corrected output code |
| out_ovf | output | 1 | Output was clamped |
| cal_done | output | 1 | Calibration capture finished |

## Verification
The hardest situations to reach are the ones where ordering on a single edge decides the outcome. One is a coefficient write landing on the same edge as a sample. Another is a calibration capture colliding with a host offset write. The bench drives both inputs in the same cycle, then uses follow-up samples to read the stored coefficient back through the arithmetic. Both clamp rails are reached by sweeping raw codes across several offset and full-scale settings in both mappings. Expected values come from a wide-integer model of the formula.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int CODE_W      = 24;
  localparam int FRAC_W      = 22;
  localparam logic [CODE_W-1:0] OFFSET_NOMINAL = 24'h800000;
  localparam logic [CODE_W-1:0] GAIN_NOMINAL   = 24'h555555;

  typedef enum logic {
    COEF_OFFSET = 1'b0,
    COEF_GAIN   = 1'b1
  } coef_sel_e;
endpackage

// File: rtl/adc_cal_coef.sv
module adc_cal_coef
  import adc_cal_pkg::*;
#(
  parameter int                W       = CODE_W,
  parameter logic [W-1:0]      OFF_RST = OFFSET_NOMINAL,
  parameter logic [W-1:0]      FS_RST  = GAIN_NOMINAL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  coef_sel_e    wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         cap_en,
  input  logic [W-1:0] cap_code,
  output logic [W-1:0] offset_q,
  output logic [W-1:0] gain_q
);
  localparam logic [W-1:0] MID = W'(1) << (W-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= OFF_RST;
      gain_q   <= FS_RST;
    end else begin
      if (wr_en && wr_sel == COEF_GAIN)
        gain_q <= wr_data;
      if (cap_en)
        offset_q <= cap_code ^ MID;
      else if (wr_en && wr_sel == COEF_OFFSET)
        offset_q <= wr_data;
    end
  end
endmodule

// File: rtl/adc_cal_sub.sv
module adc_cal_sub
  import adc_cal_pkg::*;
#(
  parameter int W      = CODE_W,
  localparam int DIFF_W = W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic [W-1:0]             smp_code,
  input  logic                     smp_bipolar,
  input  logic [W-1:0]             offset_q,
  input  logic [W-1:0]             gain_q,
  output logic                     s1_valid,
  output logic signed [DIFF_W-1:0] s1_diff,
  output logic [W-1:0]             s1_gain,
  output logic                     s1_bipolar
);
  localparam logic [W-1:0] MID = W'(1) << (W-1);

  logic [W-1:0]             off_rel;
  logic signed [DIFF_W-1:0] diff_d;

  always_comb begin
    off_rel = offset_q ^ MID;
    diff_d  = $signed({smp_code[W-1], smp_code}) - $signed({off_rel[W-1], off_rel});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_diff    <= '0;
      s1_gain    <= '0;
      s1_bipolar <= 1'b0;
    end else begin
      s1_valid <= smp_valid;
      if (smp_valid) begin
        s1_diff    <= diff_d;
        s1_gain    <= gain_q;
        s1_bipolar <= smp_bipolar;
      end
    end
  end
endmodule

// File: rtl/adc_cal_scale.sv
module adc_cal_scale
  import adc_cal_pkg::*;
#(
  parameter int W       = CODE_W,
  parameter int FRAC    = FRAC_W,
  localparam int DIFF_W = W + 1,
  localparam int PROD_W = DIFF_W + W + 1,
  localparam int SCL_W  = PROD_W - FRAC,
  localparam int MAP_W  = SCL_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  logic signed [DIFF_W-1:0] s1_diff,
  input  logic [W-1:0]             s1_gain,
  input  logic                     s1_bipolar,
  output logic                     out_valid,
  output logic [W-1:0]             out_code,
  output logic                     out_ovf
);
  localparam logic signed [MAP_W-1:0] MID_M = MAP_W'(longint'(1) << (W-1));
  localparam logic signed [MAP_W-1:0] TOP_M = MAP_W'((longint'(1) << W) - 1);

  logic signed [PROD_W-1:0] diff_x, gain_x, prod;
  logic signed [SCL_W-1:0]  scaled;
  logic signed [MAP_W-1:0]  mapped;
  logic [W-1:0]             code_d;
  logic                     ovf_d;

  always_comb begin
    diff_x = PROD_W'(s1_diff);
    gain_x = PROD_W'($signed({1'b0, s1_gain}));
    prod   = diff_x * gain_x;
    scaled = SCL_W'(prod >>> FRAC);
    if (s1_bipolar)
      mapped = MAP_W'(scaled) + MID_M;
    else
      mapped = MAP_W'(scaled) <<< 1;
    if (mapped < 0) begin
      code_d = '0;
      ovf_d  = 1'b1;
    end else if (mapped > TOP_M) begin
      code_d = '1;
      ovf_d  = 1'b1;
    end else begin
      code_d = mapped[W-1:0];
      ovf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_ovf   <= s1_valid && ovf_d;
      if (s1_valid)
        out_code <= code_d;
    end
  end
endmodule

// File: rtl/adc_cal_datapath.sv
module adc_cal_datapath
  import adc_cal_pkg::*;
#(
  parameter int           W       = CODE_W,
  parameter int           FRAC    = FRAC_W,
  parameter logic [W-1:0] OFF_RST = OFFSET_NOMINAL,
  parameter logic [W-1:0] FS_RST  = GAIN_NOMINAL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_code,
  input  logic         cal_req,
  input  logic         mode_bipolar,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         out_valid,
  output logic [W-1:0] out_code,
  output logic         out_ovf,
  output logic         cal_done
);
  localparam int DIFF_W = W + 1;

  logic                     smp_valid, cap_en;
  logic [W-1:0]             offset_q, gain_q;
  logic                     s1_valid, s1_bipolar;
  logic signed [DIFF_W-1:0] s1_diff;
  logic [W-1:0]             s1_gain;
  coef_sel_e                sel;

  assign smp_valid = in_valid && !cal_req;
  assign cap_en    = in_valid && cal_req;
  assign sel       = coef_sel_e'(wr_sel);

  adc_cal_coef #(.W(W), .OFF_RST(OFF_RST), .FS_RST(FS_RST)) u_coef (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (sel),
    .wr_data  (wr_data),
    .cap_en   (cap_en),
    .cap_code (in_code),
    .offset_q (offset_q),
    .gain_q   (gain_q)
  );

  adc_cal_sub #(.W(W)) u_sub (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .smp_code    (in_code),
    .smp_bipolar (mode_bipolar),
    .offset_q    (offset_q),
    .gain_q      (gain_q),
    .s1_valid    (s1_valid),
    .s1_diff     (s1_diff),
    .s1_gain     (s1_gain),
    .s1_bipolar  (s1_bipolar)
  );

  adc_cal_scale #(.W(W), .FRAC(FRAC)) u_scale (
    .clk        (clk),
    .rst        (rst),
    .s1_valid   (s1_valid),
    .s1_diff    (s1_diff),
    .s1_gain    (s1_gain),
    .s1_bipolar (s1_bipolar),
    .out_valid  (out_valid),
    .out_code   (out_code),
    .out_ovf    (out_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) cal_done <= 1'b0;
    else     cal_done <= cap_en;
  end
endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         cal_req,
  input logic         out_valid,
  input logic [W-1:0] out_code,
  input logic         out_ovf,
  input logic         cal_done
);
  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cal_req) |=> ##1 out_valid);                          // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !cal_req) |=> ##1 !out_valid);                        // R8
  AST_CAL_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cal_req) |=> cal_done);                                // R8
  AST_CAL_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> $past(in_valid && cal_req));                           // R8
  AST_OVF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> out_valid);                                             // R5
  AST_OVF_AT_RAIL: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_code == '0 || out_code == '1));                    // R5
endmodule

bind adc_cal_datapath adc_cal_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cal_req   (cal_req),
  .out_valid (out_valid),
  .out_code  (out_code),
  .out_ovf   (out_ovf),
  .cal_done  (cal_done)
);

// File: tb/sim_adc_cal_datapath.sv
`timescale 1ns/1ps
module sim_adc_cal_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, cal_req = 1'b0, mode_bipolar = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [23:0] in_code = '0, wr_data = '0;
  logic        out_valid, out_ovf, cal_done;
  logic [23:0] out_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [23:0] m_off = 24'h800000;
  logic [23:0] m_fs  = 24'h555555;

  always #10 clk = ~clk;

  adc_cal_datapath u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .cal_req(cal_req), .mode_bipolar(mode_bipolar), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .out_valid(out_valid),
    .out_code(out_code), .out_ovf(out_ovf), .cal_done(cal_done)
  );

  function automatic logic [24:0] model(logic [23:0] raw, logic [23:0] off,
                                        logic [23:0] fs, bit bip);
    longint r, o, d, p, s, y;
    r = raw[23] ? longint'(raw) - (longint'(1) << 24) : longint'(raw);
    o = longint'(off) - (longint'(1) << 23);
    d = r - o;
    p = d * longint'(fs);
    s = p >>> 22;
    y = bip ? s + (longint'(1) << 23) : 2 * s;
    if (y < 0) return {1'b1, 24'h000000};
    if (y > 64'sd16777215) return {1'b1, 24'hFFFFFF};
    return {1'b0, y[23:0]};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_coef(bit sel, logic [23:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (sel) m_fs = data; else m_off = data;
  endtask

  task automatic run(logic [23:0] raw, bit bip, string req);
    logic [24:0] e;
    e = model(raw, m_off, m_fs, bip);
    in_valid = 1'b1; in_code = raw; mode_bipolar = bip;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R6", longint'(out_valid), 0);
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b1, "R6", longint'(out_valid), 1);
    check(out_code == e[23:0], e[24] ? "R5" : req, longint'(out_code), longint'(e[23:0]));
    check(out_ovf == e[24], "R5", longint'(out_ovf), longint'(e[24]));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] raws[24];
    logic [23:0] fss[4];
    logic [23:0] offs[4];
    logic [24:0] e0, e1, e2;
    fss  = '{24'h555555, 24'h400000, 24'h7FFFFF, 24'hFFFFFF};
    offs = '{24'h800000, 24'h7FFF00, 24'h812345, 24'h000000};
    for (int i = 0; i < 19; i++) raws[i] = 24'((i * 32'h0069_7F13) ^ (i << 19));
    raws[19] = 24'h000000; raws[20] = 24'h7FFFFF; raws[21] = 24'h800000;
    raws[22] = 24'hFFFFFF; raws[23] = 24'h000001;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle outputs after reset
    check(out_valid == 0 && out_ovf == 0 && cal_done == 0, "R1",
          {out_valid, out_ovf, cal_done}, 0);
    // R1: nominal coefficients seen through the arithmetic
    run(24'h000000, 1'b1, "R1");
    run(24'h030000, 1'b0, "R1");

    // R2 R3 R4 R5 R7: sweep over coefficients, raw codes and both mappings
    foreach (fss[f]) begin
      write_coef(1'b1, fss[f]);
      foreach (offs[o]) begin
        write_coef(1'b0, offs[o]);
        foreach (raws[k]) begin
          run(raws[k], 1'b0, "R3");
          run(raws[k], 1'b1, "R4");
        end
      end
    end

    // R2: one offset step moves the output by fs/2^22 (unity gain: exactly 1)
    write_coef(1'b1, 24'h400000);
    write_coef(1'b0, 24'h800001);
    run(24'h000010, 1'b1, "R2");
    check(out_code == 24'h80000F, "R2", out_code, 24'h80000F);

    // R7: write on the same edge as a sample uses the old coefficient
    write_coef(1'b1, 24'h555555);
    e0 = model(24'h123456, m_off, m_fs, 1'b1);
    in_valid = 1'b1; in_code = 24'h123456; mode_bipolar = 1'b1;
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 24'h200000;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check(out_valid && out_code == e0[23:0], "R7", out_code, e0[23:0]);
    m_fs = 24'h200000;
    run(24'h123456, 1'b1, "R7");

    // R6: back-to-back stream
    e0 = model(24'h100000, m_off, m_fs, 1'b0);
    e1 = model(24'hF00000, m_off, m_fs, 1'b1);
    e2 = model(24'h000abc, m_off, m_fs, 1'b1);
    for (int k = 0; k < 5; k++) begin
      in_valid = (k < 3);
      in_code = (k == 0) ? 24'h100000 : (k == 1) ? 24'hF00000 : 24'h000abc;
      mode_bipolar = (k != 0);
      @(posedge clk); @(negedge clk);
      if (k >= 1 && k <= 3) begin
        check(out_valid == 1'b1, "R6", out_valid, 1);
        check(out_code == ((k == 1) ? e0[23:0] : (k == 2) ? e1[23:0] : e2[23:0]),
              "R6", out_code, (k == 1) ? e0[23:0] : (k == 2) ? e1[23:0] : e2[23:0]);
      end
      if (k == 4) check(out_valid == 1'b0, "R6", out_valid, 0);
    end

    // R8: zero-scale calibration capture
    write_coef(1'b1, 24'h555555);
    in_valid = 1'b1; cal_req = 1'b1; in_code = 24'hFF1234;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; cal_req = 1'b0;
    check(cal_done == 1'b1, "R8", cal_done, 1);
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R8", out_valid, 0);
    check(cal_done == 1'b0, "R8", cal_done, 0);
    m_off = 24'hFF1234 ^ 24'h800000;
    run(24'hFF1234, 1'b1, "R8");
    check(out_code == 24'h800000, "R8", out_code, 24'h800000);
    run(24'hFF1234, 1'b0, "R8");
    check(out_code == 24'h000000 && !out_ovf, "R8", out_code, 0);
    run(24'h001000, 1'b1, "R8");

    // R9: calibration beats a simultaneous offset write
    in_valid = 1'b1; cal_req = 1'b1; in_code = 24'h054321;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 24'h123456;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; cal_req = 1'b0; wr_en = 1'b0;
    check(cal_done == 1'b1, "R9", cal_done, 1);
    m_off = 24'h054321 ^ 24'h800000;
    run(24'h054321, 1'b1, "R9");
    check(out_code == 24'h800000, "R9", out_code, 24'h800000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule